// File: doc/BRIEF.md
# Chained Performance Counter Bank

This block is a bank of event counters plus one dedicated cycle counter. The cycle counter always sits at index 31. Event counters sit at indices 0 to NCNT-1 and are clocked by single-cycle event pulses. Each pulse input stands for one event number. Each event counter is programmed with the event number it counts. The cycle counter counts a separate cycle tick input.

Software controls the bank through a simple register port. A write takes effect at the next clock edge. Read data is a combinational function of the address. The registers are:
- a control word with a global enable, two bulk-clear actions and two long-overflow selects;
- set and clear aliases for the counter-enable, interrupt-enable and overflow-status bit vectors;
- a software-increment strobe;
- one event-type register and one value register per counter.

When a counter wraps, its overflow-status bit is set. An even event counter that wraps can also feed one increment into its odd neighbour, so the pair forms a single wider count. A level-sensitive interrupt is raised while any enabled overflow is pending.

Top module: `chained_counter_bank`

## Requirements
- R1: After reset, the following all read zero: every counter, the enable, interrupt-enable and overflow vectors, and the control bits E (bit 0), LC (bit 3) and LP (bit 4). The read-only field at control bits [12:8] returns NCNT, and the interrupt output is low.
- R2: A counter advances by one per cycle only when E is set and the counter's enable bit is set. An event counter advances when the pulse input indexed by its event type is high in that cycle. Type 0x00 (software increment) and type 0x1E (chain) never count from the pulse inputs.
- R3: Take an event counter whose overflow mode is 32-bit. When its low 32 bits wrap from 0xFFFFFFFF to zero, bit i of the overflow vector is set. That bit stays set until it is written through the clear alias.
- R4: The cycle counter is 64 bits wide and counts the cycle tick input. With LC clear, it flags overflow (bit 31) when its low 32 bits wrap. With LC set, it flags overflow only when all 64 bits wrap to zero.
- R5: With the extended parameter EXT64 set, event counters are 64 bits wide, and with LP set they flag overflow only on a 64-bit wrap. With EXT64 clear, LP always reads back zero whatever is written.
- R6: When even counter i overflows and its overflow mode is not 64-bit, counter i+1 gets one increment in the same cycle. This happens only if counter i+1 is implemented, enabled, has type 0x1E, and E is set. No increment is delivered otherwise.
- R7: Writing address 0x07 with a bit mask adds one to each enabled event counter selected by the mask whose type is 0x00. Other counters are unaffected, and so is the cycle counter even if bit 31 is set in the mask.
- R8: An event-type register (address 0x20+i) keeps only its low 16 bits. The other written bits read back as zero.
- R9: Writing control (address 0x00) with bit 2 set clears the cycle counter. Writing it with bit 1 set clears every implemented event counter and leaves the cycle counter unchanged.
- R10: The interrupt output is high exactly when E is set and the AND of the overflow, enable and interrupt-enable vectors is non-zero.
- R11: Set aliases are 0x01 (enable), 0x03 (interrupt enable) and 0x05 (overflow). Clear aliases are 0x02, 0x04 and 0x06. Writing 1 to a bit sets or clears that bit, and writing 0 has no effect. Only bits in the valid mask (the low NCNT bits plus bit 31) can ever become set. Either alias reads back the vector.
- R12: A write to a value register (address 0x40+i, with index 31 the cycle counter) loads that counter, and reads return its current value zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register address for reads and writes |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for reg_addr |
| ev_pulse | input | EV_IN | One pulse line per event number |
| cyc_tick | input | 1 | Cycle tick for the cycle counter |
| ovf_irq | output | 1 | Level-sensitive overflow interrupt |

## Verification
The hardest situations to reach from the ports are the wrap points. These are a chained increment landing in the odd neighbour in the same cycle as the even counter's wrap, and the 64-bit wrap of the cycle counter. The stimulus reaches both by preloading the counters through their value registers to a few counts below the wrap boundary, then supplying a small number of event pulses or ticks. The long-overflow cases are run on a second instance built with the extended parameter. There the same preload shows whether a 32-bit boundary does or does not raise overflow and chain.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
  localparam int ADDR_W = 7;
  // address regions, selected by reg_addr[6:5]
  localparam logic [1:0] RGN_MISC = 2'b00;
  localparam logic [1:0] RGN_TYPE = 2'b01;
  localparam logic [1:0] RGN_CNT  = 2'b10;
  // misc region offsets
  localparam logic [4:0] OFS_CTRL  = 5'd0;
  localparam logic [4:0] OFS_ENSET = 5'd1;
  localparam logic [4:0] OFS_ENCLR = 5'd2;
  localparam logic [4:0] OFS_IESET = 5'd3;
  localparam logic [4:0] OFS_IECLR = 5'd4;
  localparam logic [4:0] OFS_OVSET = 5'd5;
  localparam logic [4:0] OFS_OVCLR = 5'd6;
  localparam logic [4:0] OFS_SWINC = 5'd7;
  // control bit positions
  localparam int CB_EN   = 0;
  localparam int CB_PRST = 1;
  localparam int CB_CRST = 2;
  localparam int CB_LC   = 3;
  localparam int CB_LP   = 4;
  localparam int CB_NLO  = 8;
  // event codes
  localparam logic [15:0] EV_SWINC = 16'h0000;
  localparam logic [15:0] EV_CHAIN = 16'h001E;
  localparam int CYC_IDX = 31;
endpackage

// File: rtl/pcb_event_match.sv
module pcb_event_match #(
  parameter int EVW   = 16,
  parameter int EV_IN = 32
) (
  input  logic [EVW-1:0]   etype,
  input  logic [EV_IN-1:0] ev_pulse,
  output logic             ev_hit,
  output logic             is_sw,
  output logic             is_chain
);
  import pcb_pkg::*;
  localparam int IW = (EV_IN > 1) ? $clog2(EV_IN) : 1;

  logic in_range;

  always_comb begin
    is_sw    = (etype == EVW'(EV_SWINC));
    is_chain = (etype == EVW'(EV_CHAIN));
    in_range = (etype < EVW'(EV_IN));
    ev_hit   = in_range && !is_sw && !is_chain && ev_pulse[etype[IW-1:0]];
  end
endmodule

// File: rtl/pcb_counter_slice.sv
module pcb_counter_slice #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         inc,
  input  logic         long_ovf,
  output logic [W-1:0] value,
  output logic         ovf
);
  logic [W-1:0] sum;
  logic [W-1:0] val_nxt;
  logic         wrap;

  always_comb begin
    sum     = value + W'(1);
    wrap    = long_ovf ? (sum == '0) : (sum[31:0] == 32'd0);
    ovf     = inc && !load && wrap;
    val_nxt = value;
    if (load)     val_nxt = load_val;
    else if (inc) val_nxt = sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           value <= '0;
    else if (load || inc) value <= val_nxt;
  end
endmodule

// File: rtl/chained_counter_bank.sv
module chained_counter_bank #(
  parameter int NCNT  = 6,
  parameter bit EXT64 = 1'b0,
  parameter int EV_IN = 32,
  parameter int EVW   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [6:0]       reg_addr,
  input  logic [63:0]      reg_wdata,
  output logic [63:0]      reg_rdata,
  input  logic [EV_IN-1:0] ev_pulse,
  input  logic             cyc_tick,
  output logic             ovf_irq
);
  import pcb_pkg::*;
  localparam int EW = EXT64 ? 64 : 32;
  localparam logic [31:0] VALID_MASK = 32'h8000_0000 | ((32'h1 << NCNT) - 32'h1);

  // reset released synchronously
  logic [1:0] rs_q;
  logic       rst_in_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_in_n = rs_q[1];

  // write decode
  logic wr_misc, wr_ctrl, wr_sw;
  logic [31:0] wd_lo;
  assign wr_misc = reg_wr && (reg_addr[6:5] == RGN_MISC);
  assign wr_ctrl = wr_misc && (reg_addr[4:0] == OFS_CTRL);
  assign wr_sw   = wr_misc && (reg_addr[4:0] == OFS_SWINC);
  assign wd_lo   = reg_wdata[31:0] & VALID_MASK;

  // control and bit-vector registers
  logic ctl_e, ctl_lc, ctl_lp, ctl_e_n, ctl_lc_n, ctl_lp_n;
  logic [31:0] cnten_q, inten_q, ovs_q, cnten_n, inten_n, ovs_n;
  logic [31:0] ovf_vec;
  logic clr_evt, clr_cyc;
  assign clr_evt = wr_ctrl && reg_wdata[CB_PRST];
  assign clr_cyc = wr_ctrl && reg_wdata[CB_CRST];

  always_comb begin
    ctl_e_n  = ctl_e;
    ctl_lc_n = ctl_lc;
    ctl_lp_n = ctl_lp;
    if (wr_ctrl) begin
      ctl_e_n  = reg_wdata[CB_EN];
      ctl_lc_n = reg_wdata[CB_LC];
      ctl_lp_n = EXT64 && reg_wdata[CB_LP];
    end
    cnten_n = cnten_q;
    inten_n = inten_q;
    if (wr_misc && reg_addr[4:0] == OFS_ENSET) cnten_n = cnten_q | wd_lo;
    if (wr_misc && reg_addr[4:0] == OFS_ENCLR) cnten_n = cnten_q & ~wd_lo;
    if (wr_misc && reg_addr[4:0] == OFS_IESET) inten_n = inten_q | wd_lo;
    if (wr_misc && reg_addr[4:0] == OFS_IECLR) inten_n = inten_q & ~wd_lo;
    ovs_n = ovs_q;
    if (wr_misc && reg_addr[4:0] == OFS_OVCLR) ovs_n = ovs_n & ~wd_lo;
    if (wr_misc && reg_addr[4:0] == OFS_OVSET) ovs_n = ovs_n | wd_lo;
    ovs_n = ovs_n | (ovf_vec & VALID_MASK);
  end

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) begin
      ctl_e   <= 1'b0;
      ctl_lc  <= 1'b0;
      ctl_lp  <= 1'b0;
      cnten_q <= '0;
      inten_q <= '0;
      ovs_q   <= '0;
    end else begin
      ctl_e   <= ctl_e_n;
      ctl_lc  <= ctl_lc_n;
      ctl_lp  <= ctl_lp_n;
      cnten_q <= cnten_n;
      inten_q <= inten_n;
      ovs_q   <= ovs_n;
    end
  end

  // counters
  logic [31:0][63:0] cnt_val;
  logic [EVW-1:0]    etype [32];

  for (genvar i = 0; i < CYC_IDX; i++) begin : g_evt
    if (i < NCNT) begin : g_impl
      logic [EVW-1:0] et_q;
      logic [EW-1:0]  val;
      logic ev_hit, is_sw, is_chain, chain_in, inc, ovf, wr_type, wr_val;
      assign wr_type = reg_wr && (reg_addr == {RGN_TYPE, 5'(i)});
      assign wr_val  = reg_wr && (reg_addr == {RGN_CNT, 5'(i)});

      always_ff @(posedge clk or negedge rst_in_n) begin
        if (!rst_in_n)    et_q <= '0;
        else if (wr_type) et_q <= reg_wdata[EVW-1:0];
      end

      pcb_event_match #(.EVW(EVW), .EV_IN(EV_IN)) u_match (
        .etype(et_q), .ev_pulse(ev_pulse),
        .ev_hit(ev_hit), .is_sw(is_sw), .is_chain(is_chain));

      if (i % 2 == 1) begin : g_odd
        assign chain_in = is_chain && ovf_vec[i-1] && !ctl_lp;
      end else begin : g_even
        assign chain_in = 1'b0;
      end

      assign inc = ctl_e && cnten_q[i] &&
                   (ev_hit || (is_sw && wr_sw && reg_wdata[i]) || chain_in);

      pcb_counter_slice #(.W(EW)) u_cnt (
        .clk(clk), .rst_n(rst_in_n),
        .load(clr_evt || wr_val),
        .load_val(clr_evt ? '0 : reg_wdata[EW-1:0]),
        .inc(inc), .long_ovf(ctl_lp),
        .value(val), .ovf(ovf));

      assign etype[i]   = et_q;
      assign cnt_val[i] = 64'(val);
      assign ovf_vec[i] = ovf;
    end else begin : g_none
      assign etype[i]   = '0;
      assign cnt_val[i] = '0;
      assign ovf_vec[i] = 1'b0;
    end
  end

  // cycle counter
  logic [63:0] cyc_val;
  logic        cyc_ovf, cyc_wr;
  assign cyc_wr = reg_wr && (reg_addr == {RGN_CNT, 5'(CYC_IDX)});
  pcb_counter_slice #(.W(64)) u_cyc (
    .clk(clk), .rst_n(rst_in_n),
    .load(clr_cyc || cyc_wr),
    .load_val(clr_cyc ? 64'd0 : reg_wdata),
    .inc(ctl_e && cnten_q[CYC_IDX] && cyc_tick),
    .long_ovf(ctl_lc),
    .value(cyc_val), .ovf(cyc_ovf));
  assign etype[CYC_IDX]   = '0;
  assign cnt_val[CYC_IDX] = cyc_val;
  assign ovf_vec[CYC_IDX] = cyc_ovf;

  // interrupt
  assign ovf_irq = ctl_e && |(ovs_q & cnten_q & inten_q);

  // read mux
  logic [63:0] ctl_rd;
  always_comb begin
    ctl_rd             = '0;
    ctl_rd[CB_EN]      = ctl_e;
    ctl_rd[CB_LC]      = ctl_lc;
    ctl_rd[CB_LP]      = ctl_lp;
    ctl_rd[CB_NLO+:5]  = 5'(NCNT);
    reg_rdata = '0;
    case (reg_addr[6:5])
      RGN_MISC: begin
        case (reg_addr[4:0])
          OFS_CTRL:             reg_rdata = ctl_rd;
          OFS_ENSET, OFS_ENCLR: reg_rdata = {32'd0, cnten_q};
          OFS_IESET, OFS_IECLR: reg_rdata = {32'd0, inten_q};
          OFS_OVSET, OFS_OVCLR: reg_rdata = {32'd0, ovs_q};
          default:              reg_rdata = '0;
        endcase
      end
      RGN_TYPE: reg_rdata = 64'(etype[reg_addr[4:0]]);
      RGN_CNT:  reg_rdata = cnt_val[reg_addr[4:0]];
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pcb_checker.sv
module pcb_checker #(
  parameter int NCNT  = 6,
  parameter bit EXT64 = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [6:0]        reg_addr,
  input logic              ctl_e,
  input logic              ctl_lp,
  input logic [31:0]       cnten_q,
  input logic [31:0]       inten_q,
  input logic [31:0]       ovs_q,
  input logic [31:0][63:0] cnt_val,
  input logic              ovf_irq
);
  localparam logic [31:0] VMASK = 32'h8000_0000 | ((32'h1 << NCNT) - 32'h1);

  AST_HALT_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_e && !reg_wr) |=> $stable(cnt_val)); // R2

  AST_OVS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == 7'h06) |=> ((ovs_q & $past(ovs_q)) == $past(ovs_q))); // R3

  AST_LP_NEEDS_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_lp |-> EXT64); // R5

  AST_IRQ_NEEDS_E: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq |-> ctl_e); // R10

  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    ((ovs_q & cnten_q & inten_q) == 32'd0) |-> !ovf_irq); // R10

  AST_VALID_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    ((ovs_q | cnten_q | inten_q) & ~VMASK) == 32'd0); // R11
endmodule

bind chained_counter_bank pcb_checker #(.NCNT(NCNT), .EXT64(EXT64)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .ctl_e(ctl_e), .ctl_lp(ctl_lp), .cnten_q(cnten_q), .inten_q(inten_q),
  .ovs_q(ovs_q), .cnt_val(cnt_val), .ovf_irq(ovf_irq));

// File: tb/sim_chained_counter_bank.sv
`timescale 1ns/1ps
module sim_chained_counter_bank;
  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic [6:0]  reg_addr;
  logic [63:0] reg_wdata;
  logic [63:0] rdata0, rdata1;
  logic [31:0] ev_pulse;
  logic        cyc_tick;
  logic        irq0, irq1;
  int checks = 0;
  int failures = 0;

  chained_counter_bank #(.NCNT(6), .EXT64(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rdata0), .ev_pulse(ev_pulse),
    .cyc_tick(cyc_tick), .ovf_irq(irq0));

  chained_counter_bank #(.NCNT(4), .EXT64(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rdata1), .ev_pulse(ev_pulse),
    .cyc_tick(cyc_tick), .ovf_irq(irq1));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=0x%0h exp=0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [63:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd0(input logic [6:0] a, output logic [63:0] v);
    reg_addr = a; #1; v = rdata0;
  endtask

  task automatic rd1(input logic [6:0] a, output logic [63:0] v);
    reg_addr = a; #1; v = rdata1;
  endtask

  task automatic pulse(input int ev, input int n);
    @(negedge clk);
    ev_pulse = 32'h1 << ev;
    repeat (n) @(negedge clk);
    ev_pulse = '0;
  endtask

  task automatic tick(input int n);
    @(negedge clk);
    cyc_tick = 1'b1;
    repeat (n) @(negedge clk);
    cyc_tick = 1'b0;
  endtask

  task automatic t_reset;
    logic [63:0] v;
    rd0(7'h00, v); chk("R1 ctrl", v, 64'h600);
    rd0(7'h40, v); chk("R1 cnt0", v, 0);
    rd0(7'h5F, v); chk("R1 cycle", v, 0);
    rd0(7'h01, v); chk("R1 enable", v, 0);
    rd0(7'h05, v); chk("R1 ovs", v, 0);
    chk("R1 irq", 64'(irq0), 0);
  endtask

  task automatic t_gate;
    logic [63:0] v;
    wr(7'h20, 64'd5);
    wr(7'h01, 64'h1);
    pulse(5, 1);
    rd0(7'h40, v); chk("R2 E off", v, 0);
    wr(7'h00, 64'h1);
    pulse(5, 3);
    rd0(7'h40, v); chk("R2 count", v, 3);
    pulse(6, 2);
    rd0(7'h40, v); chk("R2 other event", v, 3);
    wr(7'h02, 64'h1);
    pulse(5, 2);
    rd0(7'h40, v); chk("R2 enable off", v, 3);
    wr(7'h21, 64'h1E);
    wr(7'h01, 64'h2);
    pulse(30, 2);
    rd0(7'h41, v); chk("R2 chain type no pulse", v, 0);
    wr(7'h00, 64'h3);
  endtask

  task automatic t_wrap_chain;
    logic [63:0] v;
    wr(7'h01, 64'h1);
    wr(7'h40, 64'hFFFF_FFFE);
    pulse(5, 1);
    rd0(7'h40, v); chk("R3 pre-wrap", v, 64'hFFFF_FFFF);
    rd0(7'h05, v); chk("R3 no ovf yet", v, 0);
    pulse(5, 1);
    rd0(7'h40, v); chk("R3 wrapped", v, 0);
    rd0(7'h05, v); chk("R3 ovf bit0", v, 1);
    rd0(7'h41, v); chk("R6 chained +1", v, 1);
    wr(7'h21, 64'd7);
    wr(7'h40, 64'hFFFF_FFFF);
    pulse(5, 1);
    rd0(7'h41, v); chk("R6 no chain non-chain type", v, 1);
  endtask

  task automatic t_irq_alias;
    logic [63:0] v;
    chk("R10 no inten", 64'(irq0), 0);
    wr(7'h03, 64'h1);
    chk("R10 irq high", 64'(irq0), 1);
    wr(7'h00, 64'h0);
    chk("R10 E off", 64'(irq0), 0);
    wr(7'h00, 64'h1);
    chk("R10 E on", 64'(irq0), 1);
    wr(7'h06, 64'h1);
    chk("R10 cleared", 64'(irq0), 0);
    wr(7'h04, 64'hFFFF_FFFF);
    wr(7'h05, 64'hFFFF_FFFF);
    rd0(7'h06, v); chk("R11 ovs valid mask", v, 64'h8000_003F);
    wr(7'h06, 64'hFFFF_FFFF);
    rd0(7'h05, v); chk("R11 ovs clear", v, 0);
    wr(7'h01, 64'hC0);
    rd0(7'h02, v); chk("R11 invalid enable bits", v, 64'h3);
  endtask

  task automatic t_swinc;
    logic [63:0] v;
    wr(7'h23, 64'd5);
    wr(7'h01, 64'h8000_000C);
    wr(7'h07, 64'h8000_000C);
    rd0(7'h42, v); chk("R7 sw counter", v, 1);
    rd0(7'h43, v); chk("R7 non-sw type", v, 0);
    rd0(7'h5F, v); chk("R7 cycle excluded", v, 0);
    wr(7'h02, 64'h4);
    wr(7'h07, 64'h4);
    rd0(7'h42, v); chk("R7 disabled", v, 1);
  endtask

  task automatic t_type;
    logic [63:0] v;
    wr(7'h24, 64'hABCD_1234_5678);
    rd0(7'h24, v); chk("R8 type field", v, 64'h5678);
  endtask

  task automatic t_cycle;
    logic [63:0] v;
    wr(7'h00, 64'h1);
    wr(7'h5F, 64'hFFFF_FFFE);
    tick(2);
    rd0(7'h5F, v); chk("R4 64-bit width", v, 64'h1_0000_0000);
    rd0(7'h05, v); chk("R4 low32 ovf", v, 64'h8000_0000);
    wr(7'h06, 64'hFFFF_FFFF);
    wr(7'h00, 64'h9);
    wr(7'h5F, 64'h1_FFFF_FFFF);
    tick(1);
    rd0(7'h5F, v); chk("R4 LC count", v, 64'h2_0000_0000);
    rd0(7'h05, v); chk("R4 LC no low32 ovf", v, 0);
    wr(7'h5F, 64'hFFFF_FFFF_FFFF_FFFF);
    tick(1);
    rd0(7'h5F, v); chk("R4 LC 64 wrap", v, 0);
    rd0(7'h05, v); chk("R4 LC ovf", v, 64'h8000_0000);
    wr(7'h06, 64'hFFFF_FFFF);
  endtask

  task automatic t_bulk;
    logic [63:0] v;
    wr(7'h00, 64'h1);
    wr(7'h40, 64'h55);
    rd0(7'h40, v); chk("R12 load", v, 64'h55);
    wr(7'h5F, 64'h77);
    wr(7'h00, 64'h5);
    rd0(7'h5F, v); chk("R9 C clears cycle", v, 0);
    rd0(7'h40, v); chk("R9 C keeps event", v, 64'h55);
    wr(7'h5F, 64'h77);
    wr(7'h00, 64'h3);
    rd0(7'h40, v); chk("R9 P clears cnt0", v, 0);
    rd0(7'h42, v); chk("R9 P clears cnt2", v, 0);
    rd0(7'h5F, v); chk("R9 P keeps cycle", v, 64'h77);
  endtask

  task automatic t_long;
    logic [63:0] v;
    wr(7'h00, 64'h11);
    rd0(7'h00, v); chk("R5 LP dropped", v, 64'h601);
    rd1(7'h00, v); chk("R5 LP kept", v, 64'h411);
    wr(7'h21, 64'h1E);
    wr(7'h06, 64'hFFFF_FFFF);
    wr(7'h40, 64'hFFFF_FFFF);
    pulse(5, 1);
    rd1(7'h40, v); chk("R5 64-bit counter", v, 64'h1_0000_0000);
    rd1(7'h05, v); chk("R5 no low32 ovf", v, 0);
    wr(7'h40, 64'hFFFF_FFFF_FFFF_FFFF);
    pulse(5, 1);
    rd1(7'h40, v); chk("R5 64 wrap", v, 0);
    rd1(7'h05, v); chk("R5 ovf on 64 wrap", v, 1);
    rd1(7'h41, v); chk("R6 no chain in long mode", v, 0);
  endtask

  initial begin
    #(8 * 100000);
    failures++;
    $display("FAIL watchdog expired got=0x0 exp=0x1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    ev_pulse = '0; cyc_tick = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_gate();
    t_wrap_chain();
    t_irq_alias();
    t_swinc();
    t_type();
    t_cycle();
    t_bulk();
    t_long();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule